// File: doc/BRIEF.md
# Passive Tag Frame Transmit Sequencer

This block produces the read-mode modulation stream of a low-frequency passive tag. It runs on the RF carrier clock, one tick per carrier period. While `en` is high it sends frames without stopping. A frame is two listen windows, then the first data word of the active range, then one listen window before each later word, up to and including the last word of the range. Words come from an external word store through a combinational read port: index `rd_addr` returns `rd_data` in the same cycle. The store holds 34 addressable words: 0 is the password, 1 is protection, 2 is control, 3 to 31 are user data, 32 is the serial number and 33 is the identification word. Words 32 and 33 are read-only.

Every frame begins with one load cycle. In that cycle the sequencer reads the control word at index 2 and takes the range from it. The one exception is a pending selective-read range captured through `sel_load`. That range is used for exactly one frame and is then discarded.

A command detector outside this block raises `cmd_det`. If `cmd_det` is seen high during a listen window, the frame is abandoned at once and a one-cycle `frame_abort` pulse reports it. The sequencer stays silent until `cmd_det` falls, and then starts a fresh frame.

The states are:
- `ST_IDLE`: disabled.
- `ST_LOAD`: range fetch.
- `ST_LISTEN`: listen window.
- `ST_WORD`: word serialisation.
- `ST_HOLD`: parked after an abort.

The transitions are:
- IDLE→LOAD when `en` rises.
- LOAD→LISTEN always.
- LISTEN→LISTEN at the end of the leading window.
- LISTEN→WORD at the end of a window when the range is not used up.
- LISTEN→LOAD at the end of the second window when the range is empty.
- LISTEN→HOLD on `cmd_det`.
- WORD→LISTEN after a word that is not the last.
- WORD→LOAD after the last word.
- HOLD→LOAD when `cmd_det` falls.
- Any state goes to IDLE when `en` is low.

Top module: `tagfrm_seq`

## Requirements
- R1: After reset, `mod_out` and `frame_abort` are 0 and the block is idle until `en` is high.
- R2: A listen window lasts 10·U ticks (U = `LW_UNIT`). Measured from the window start, it is high for U ticks, low for U, high for 4·U, low for 2·U, then high for 2·U.
- R3: `mod_out` is 0 for the one load cycle that opens each frame. Two listen windows follow, then the first word, then a listen window before each further word. After the last word the next frame begins with its own load cycle.
- R4: In normal read mode, the first word index is bits 5:0 of word 2 and the last word index is bits 13:8 of word 2. Both are sampled in the load cycle.
- R5: Each word is sent most significant bit first, as 32 cells of `BIT_LEN` ticks each. A 1 is high for the first half of its cell and low for the second half. A 0 is the opposite.
- R6: If the last index is below the first index, no words are sent and each frame is a load cycle plus two listen windows.
- R7: `cmd_det` sampled high during a listen window gives `frame_abort` = 1 for exactly the next cycle. After that, `mod_out` stays 0 and no word is sent while `cmd_det` stays high. The cycle after `cmd_det` is seen low, a new frame starts with its load cycle.
- R8: `cmd_det` while a word is being sent has no effect: the word stream continues unchanged and no abort is reported.
- R9: A `sel_load` pulse captures `sel_first`/`sel_last`. The next frame uses that range once, including read-only words 32 and 33. The frame after that uses the range from word 2 again.
- R10: While `en` is low, `mod_out` is 0 in the same cycle. When `en` is raised again, transmission restarts from a frame's load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF carrier clock, one tick per carrier period |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Transmission enable |
| cmd_det | input | 1 | Reader command detected |
| sel_load | input | 1 | Capture a one-shot selective range |
| sel_first | input | ADDR_W | Selective first word index |
| sel_last | input | ADDR_W | Selective last word index |
| rd_addr | output | ADDR_W | Word store read index |
| rd_data | input | WORD_W | Word store read data, same cycle |
| mod_out | output | 1 | Modulation output |
| frame_abort | output | 1 | One-cycle pulse when a frame is abandoned |

## Verification
The bench builds the block with `LW_UNIT` = 2 and `BIT_LEN` = 4. A listen window is then 20 ticks and a word is 128 ticks. Every segment edge, every Manchester half-cell and every frame boundary of a multi-word frame can therefore be compared tick by tick within a few hundred cycles. These short timings also let the bench run the empty range, the selective range that reaches words 32 and 33, the abort in the middle of a window and the restart after enable is dropped.

// File: rtl/tagfrm_pkg.sv
package tagfrm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LISTEN,
        ST_WORD,
        ST_HOLD
    } tf_state_e;
endpackage

// File: rtl/tagfrm_liw_wave.sv
// Level of a listen window as a function of the tick count since its start.
module tagfrm_liw_wave #(
    parameter int UNIT  = 32,
    parameter int CNT_W = 9
) (
    input  logic [CNT_W-1:0] cnt,
    output logic             level
);
    localparam logic [CNT_W-1:0] E1 = CNT_W'(UNIT);
    localparam logic [CNT_W-1:0] E2 = CNT_W'(2 * UNIT);
    localparam logic [CNT_W-1:0] E3 = CNT_W'(6 * UNIT);
    localparam logic [CNT_W-1:0] E4 = CNT_W'(8 * UNIT);

    always_comb begin
        if (cnt < E1)      level = 1'b1;
        else if (cnt < E2) level = 1'b0;
        else if (cnt < E3) level = 1'b1;
        else if (cnt < E4) level = 1'b0;
        else               level = 1'b1;
    end
endmodule

// File: rtl/tagfrm_manch.sv
// Manchester cell level: a 1 is high then low, a 0 is low then high.
module tagfrm_manch #(
    parameter int BIT_LEN = 64,
    parameter int CC_W    = 6
) (
    input  logic            bit_val,
    input  logic [CC_W-1:0] cc,
    output logic            level
);
    localparam logic [CC_W-1:0] HALF = CC_W'(BIT_LEN / 2);

    assign level = (cc < HALF) ? bit_val : ~bit_val;
endmodule

// File: rtl/tagfrm_seq.sv
module tagfrm_seq
    import tagfrm_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int ADDR_W    = 6,
    parameter int LW_UNIT   = 32,
    parameter int BIT_LEN   = 64,
    parameter int CTL_ADDR  = 2,
    parameter int FIRST_LSB = 0,
    parameter int LAST_LSB  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cmd_det,
    input  logic              sel_load,
    input  logic [ADDR_W-1:0] sel_first,
    input  logic [ADDR_W-1:0] sel_last,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [WORD_W-1:0] rd_data,
    output logic              mod_out,
    output logic              frame_abort
);
    localparam int LW_LEN = 10 * LW_UNIT;
    localparam int LW_CW  = $clog2(LW_LEN);
    localparam int CC_W   = $clog2(BIT_LEN);
    localparam int BN_W   = $clog2(WORD_W);
    localparam logic [LW_CW-1:0] LW_LAST = LW_CW'(LW_LEN - 1);
    localparam logic [CC_W-1:0]  CC_LAST = CC_W'(BIT_LEN - 1);
    localparam logic [BN_W-1:0]  BN_LAST = BN_W'(WORD_W - 1);

    tf_state_e state_q, state_d;

    logic [LW_CW-1:0]  lw_cnt_q;
    logic [CC_W-1:0]   cc_q;
    logic [BN_W-1:0]   bn_q;
    logic [WORD_W-1:0] sh_q;
    logic [ADDR_W-1:0] widx_q, last_q;
    logic [ADDR_W-1:0] sel_first_q, sel_last_q;
    logic              sel_pend_q;
    logic              pre_q;
    logic              abort_q;

    logic lw_end, cell_end, word_end;
    logic liw_lvl, man_lvl;

    assign lw_end   = (lw_cnt_q == LW_LAST);
    assign cell_end = (cc_q == CC_LAST);
    assign word_end = cell_end && (bn_q == BN_LAST);

    tagfrm_liw_wave #(.UNIT(LW_UNIT), .CNT_W(LW_CW)) u_liw (
        .cnt   (lw_cnt_q),
        .level (liw_lvl)
    );

    tagfrm_manch #(.BIT_LEN(BIT_LEN), .CC_W(CC_W)) u_manch (
        .bit_val (sh_q[WORD_W-1]),
        .cc      (cc_q),
        .level   (man_lvl)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = ST_LOAD;
            ST_LOAD:   state_d = ST_LISTEN;
            ST_LISTEN: begin
                if (cmd_det)       state_d = ST_HOLD;
                else if (lw_end) begin
                    if (pre_q)                state_d = ST_LISTEN;
                    else if (widx_q > last_q) state_d = ST_LOAD;
                    else                      state_d = ST_WORD;
                end
            end
            ST_WORD: begin
                if (word_end) state_d = (widx_q == last_q) ? ST_LOAD : ST_LISTEN;
            end
            ST_HOLD:   if (!cmd_det) state_d = ST_LOAD;
            default:   state_d = ST_IDLE;
        endcase
        if (!en) state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath: counters, range and word shifter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lw_cnt_q    <= '0;
            cc_q        <= '0;
            bn_q        <= '0;
            sh_q        <= '0;
            widx_q      <= '0;
            last_q      <= '0;
            sel_first_q <= '0;
            sel_last_q  <= '0;
            sel_pend_q  <= 1'b0;
            pre_q       <= 1'b0;
            abort_q     <= 1'b0;
        end else begin
            abort_q <= en && (state_q == ST_LISTEN) && cmd_det;
            unique case (state_q)
                ST_LOAD: if (en) begin
                    lw_cnt_q <= '0;
                    pre_q    <= 1'b1;
                    if (sel_pend_q) begin
                        widx_q     <= sel_first_q;
                        last_q     <= sel_last_q;
                        sel_pend_q <= 1'b0;
                    end else begin
                        widx_q <= rd_data[FIRST_LSB +: ADDR_W];
                        last_q <= rd_data[LAST_LSB +: ADDR_W];
                    end
                end
                ST_LISTEN: begin
                    lw_cnt_q <= lw_end ? '0 : lw_cnt_q + 1'b1;
                    cc_q     <= '0;
                    bn_q     <= '0;
                    if (lw_end) begin
                        pre_q <= 1'b0;
                        sh_q  <= rd_data;
                    end
                end
                ST_WORD: begin
                    lw_cnt_q <= '0;
                    if (cell_end) begin
                        cc_q <= '0;
                        bn_q <= bn_q + 1'b1;
                        sh_q <= {sh_q[WORD_W-2:0], 1'b0};
                        if (word_end) widx_q <= widx_q + 1'b1;
                    end else begin
                        cc_q <= cc_q + 1'b1;
                    end
                end
                default: ;
            endcase
            if (sel_load) begin
                sel_first_q <= sel_first;
                sel_last_q  <= sel_last;
                sel_pend_q  <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rd_addr     = (state_q == ST_LOAD) ? ADDR_W'(CTL_ADDR) : widx_q;
        frame_abort = abort_q;
        unique case (state_q)
            ST_LISTEN: mod_out = en & liw_lvl;
            ST_WORD:   mod_out = en & man_lvl;
            default:   mod_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/tagfrm_seq_chk.sv
module tagfrm_seq_chk
    import tagfrm_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      en,
    input logic      cmd_det,
    input logic      mod_out,
    input logic      frame_abort,
    input tf_state_e state
);
    a_r10_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !mod_out);

    a_r7_abort_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |=> !frame_abort);

    a_r7_abort_cause: assert property (@(posedge clk) disable iff (!rst_n)
        frame_abort |-> ($past(cmd_det) && $past(state) == ST_LISTEN));

    a_r7_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !mod_out);

    a_r7_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && cmd_det && en) |=> (state == ST_HOLD));

    a_r8_word_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WORD) |=> !frame_abort);
endmodule

bind tagfrm_seq tagfrm_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .cmd_det     (cmd_det),
    .mod_out     (mod_out),
    .frame_abort (frame_abort),
    .state       (state_q)
);

// File: tb/tagfrm_seq_bench.sv
module tagfrm_seq_bench;
    localparam int U  = 2;
    localparam int BL = 4;
    localparam int LW = 10 * U;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cmd_det = 1'b0;
    logic        sel_load = 1'b0;
    logic [5:0]  sel_first = '0;
    logic [5:0]  sel_last = '0;
    logic [5:0]  rd_addr;
    logic [31:0] rd_data;
    logic        mod_out;
    logic        frame_abort;

    logic [31:0] mem [34];
    int n_cmp = 0;
    int n_bad = 0;
    logic  exp_q [$];
    string tag_q [$];

    always #2 clk = ~clk;

    assign rd_data = (rd_addr < 6'd34) ? mem[rd_addr] : 32'h0;

    tagfrm_seq #(.LW_UNIT(U), .BIT_LEN(BL)) u_tagfrm_seq (
        .clk(clk), .rst_n(rst_n), .en(en), .cmd_det(cmd_det),
        .sel_load(sel_load), .sel_first(sel_first), .sel_last(sel_last),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .mod_out(mod_out), .frame_abort(frame_abort)
    );

    function automatic logic lw_lvl(int t);
        if (t < U)     return 1'b1;
        if (t < 2 * U) return 1'b0;
        if (t < 6 * U) return 1'b1;
        if (t < 8 * U) return 1'b0;
        return 1'b1;
    endfunction

    task automatic push(logic v, string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic push_lw(int upto);
        for (int t = 0; t < upto; t++) push(lw_lvl(t), "R2");
    endtask

    task automatic push_word(logic [31:0] w);
        for (int b = 31; b >= 0; b--)
            for (int c = 0; c < BL; c++)
                push((c < BL / 2) ? w[b] : ~w[b], "R5");
    endtask

    task automatic push_frame(int first, int last);
        push(1'b0, "R3");
        push_lw(LW);
        push_lw(LW);
        for (int i = first; i <= last; i++) begin
            if (i != first) push_lw(LW);
            push_word(mem[i]);
        end
    endtask

    task automatic check(string tag, logic got, logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        @(posedge clk); #1;
    endtask

    // monitor: compares the modulation stream against the scoreboard
    always @(posedge clk) begin
        #3;
        if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (mod_out !== e) begin
                n_bad++;
                $display("FAIL %s: mod_out got %0b expected %0b at %0t", t, mod_out, e, $time);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 34; i++) mem[i] = 32'h9E37_79B9 * (i + 1) ^ (i << 20);
        mem[2]  = (32'd5 << 8) | 32'd3;
        mem[3]  = 32'hFFFF_FFFF;
        mem[4]  = 32'h0000_0000;
        mem[32] = 32'hA5C3_0F81;
        mem[33] = 32'h1234_5678;

        // R1: reset state
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 mod_out", mod_out, 1'b0);
        check("R1 frame_abort", frame_abort, 1'b0);

        // R3/R4/R5: control range 3..5, two frames; R8: cmd pulse inside first word
        en = 1'b1;
        push(1'b0, "R10");
        push_frame(3, 5);
        push_frame(3, 5);
        repeat (47) @(posedge clk);
        #1 cmd_det = 1'b1;
        @(posedge clk); #1 cmd_det = 1'b0;
        check("R8 no abort in word", frame_abort, 1'b0);
        @(posedge clk); #1;
        check("R8 no abort in word", frame_abort, 1'b0);
        drain();
        en = 1'b0;
        #1 check("R10 disabled", mod_out, 1'b0);
        @(posedge clk); #1;

        // R6: empty range
        mem[2] = (32'd4 << 8) | 32'd7;
        en = 1'b1;
        push(1'b0, "R10");
        push_frame(7, 4);
        push_frame(7, 4);
        drain();
        en = 1'b0;
        @(posedge clk); #1;

        // R9: selective range reaching read-only words, then back to control range
        mem[2] = (32'd4 << 8) | 32'd3;
        sel_first = 6'd31; sel_last = 6'd33; sel_load = 1'b1;
        @(posedge clk); #1 sel_load = 1'b0;
        en = 1'b1;
        push(1'b0, "R10");
        push_frame(31, 33);
        push_frame(3, 4);
        drain();
        en = 1'b0;
        @(posedge clk); #1;

        // R7: abort during the second listen window
        en = 1'b1;
        push(1'b0, "R10");
        push(1'b0, "R3");
        push_lw(LW);
        push_lw(7);
        drain();
        cmd_det = 1'b1;
        @(posedge clk); #1;
        check("R7 abort pulse", frame_abort, 1'b1);
        check("R7 quiet after abort", mod_out, 1'b0);
        for (int k = 0; k < 30; k++) begin
            @(posedge clk); #1;
            check("R7 single pulse", frame_abort, 1'b0);
            check("R7 quiet while held", mod_out, 1'b0);
        end
        cmd_det = 1'b0;
        push(1'b0, "R7");
        push_frame(3, 4);
        drain();

        // R10: drop enable while output is high, then restart at a frame start
        wait (mod_out == 1'b1);
        @(posedge clk); #1;
        en = 1'b0;
        #1 check("R10 same-cycle low", mod_out, 1'b0);
        repeat (5) begin
            @(posedge clk); #1;
            check("R10 stays low", mod_out, 1'b0);
        end
        en = 1'b1;
        push(1'b0, "R10");
        push_frame(3, 4);
        drain();
        en = 1'b0;
        @(posedge clk); #1;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule